// File: doc/BRIEF.md
# Locked IDE Timing Configuration Window

This block sits on the 8-bit I/O decode of one IDE channel. While it is locked, every access from the host side goes straight on to the ATA task-file registers, and their read data comes back unchanged. A short, fixed access sequence opens the window.

While the window is open, the same offsets reach a small bank of configuration registers instead, and the task file sees no strobe at all. Through that bank, software stages a read-cycle timing, a write-cycle timing and an address-setup field for each of two drives. It then commits all staged values with a control-register write. A further key write closes the window again.

A drive-select input picks which committed timing set the block presents on its active-timing outputs. Those outputs drive the bus cycle generator, and they change only on a commit.

Top module: `ide_cfg_window`

## Requirements
- R1: The window opens on an 8-bit write of 0x03 to offset 2 when the two accesses just before it were both 16-bit reads at offset 1. `win_open` is high from the clock edge that accepts that write.
- R2: Any other pattern leaves the window locked. This includes a single read, an access at another offset, an 8-bit read at offset 1, an intervening write, or a wrong key value. While locked, each access is forwarded to the task-file port, and `acc_rdata` equals `tf_rdata`.
- R3: While the window is open, `tf_vld` stays low and reads return configuration-bank data, not task-file data.
- R4: While open, an 8-bit write of 0x83 to offset 2 closes the window. Any other value written there has no effect.
- R5: While open, a write to offset 0 stages the read-cycle timing, and a write to offset 1 stages the write-cycle timing, of the drive selected by the miscellaneous register. Reads at offsets 0 and 1 return the staged value for that drive.
- R6: While open, a write to offset 6 (the miscellaneous register) does two things. Bit 0 selects the drive, and bits 7:4 are stored as that drive's address-setup field. A read at offset 6 returns {address field of the selected drive, 3'b000, select}.
- R7: While open, writing 0x85 to offset 3 copies every drive's staged values into the committed set. Other values commit nothing. A read at offset 3 returns the last value written there.
- R8: `act_rd_tim`, `act_wr_tim` and `act_addr` show the committed values of the drive chosen by `drv_sel`. They change only on a commit.
- R9: A read at offset 5 returns the clock strap in bit 0 (0 = 33 MHz, 1 = 25 MHz) and zero in bits 7:1. The strap is sampled from `strap_pin` while reset is asserted, and writes to offset 5 are ignored.
- R10: After reset the window is locked, and all staged values, committed values, the drive select and the control value are zero.
- R11: While open, offsets 4 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Host access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| acc_ofs | input | 3 | Register offset |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data (combinational) |
| tf_vld | output | 1 | Forwarded task-file strobe |
| tf_wr | output | 1 | Forwarded write flag |
| tf_wide | output | 1 | Forwarded width flag |
| tf_ofs | output | 3 | Forwarded offset |
| tf_wdata | output | 8 | Forwarded write data |
| tf_rdata | input | 8 | Task-file read data |
| strap_pin | input | 1 | Bus clock strap |
| drv_sel | input | 1 | Drive whose committed timing is shown |
| win_open | output | 1 | Window open flag |
| act_rd_tim | output | 8 | Committed read-cycle timing |
| act_wr_tim | output | 8 | Committed write-cycle timing |
| act_addr | output | 4 | Committed address-setup field |

## Verification
Read data and the task-file forwarding are combinational, so they are due in the same cycle as the access. The bench drives each access at a falling edge and samples them 1 ns later, before the rising edge. The window state, staged values and committed outputs are registered and change at the rising edge that accepts the access. The bench therefore checks them only after the next falling edge, once the access strobe has been dropped. Because `drv_sel` reaches the active outputs combinationally, the bench changes it at a falling edge and samples 1 ns later.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

   // progress of the open sequence
   typedef enum logic [1:0] {
      TRK_IDLE = 2'd0,
      TRK_ONE  = 2'd1,
      TRK_TWO  = 2'd2
   } trk_st_t;

   // next tracker state for one accepted access while locked
   function automatic trk_st_t trk_next(input trk_st_t cur, input logic qual_rd);
      trk_st_t nx;
      if (!qual_rd)                nx = TRK_IDLE;
      else if (cur == TRK_IDLE)    nx = TRK_ONE;
      else                         nx = TRK_TWO;
      return nx;
   endfunction

endpackage

// File: rtl/ide_win_lock.sv
module ide_win_lock
   import ide_win_pkg::*;
#(
   parameter int OFS_W      = 3,
   parameter int DAT_W      = 8,
   parameter int OFS_SEQ    = 1,
   parameter int OFS_KEY    = 2,
   parameter int UNLOCK_KEY = 8'h03,
   parameter int RELOCK_KEY = 8'h83
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_vld,
   input  logic             acc_wr,
   input  logic             acc_wide,
   input  logic [OFS_W-1:0] acc_ofs,
   input  logic [DAT_W-1:0] acc_wdata,
   output logic             open_o
);

   trk_st_t trk_q;
   logic    open_q;
   logic    qual_rd, key_wr, do_open, do_close;

   always_comb begin
      qual_rd  = acc_vld && !acc_wr && acc_wide && (acc_ofs == OFS_W'(OFS_SEQ));
      key_wr   = acc_vld && acc_wr && !acc_wide && (acc_ofs == OFS_W'(OFS_KEY));
      do_open  = !open_q && (trk_q == TRK_TWO) && key_wr
                 && (acc_wdata == DAT_W'(UNLOCK_KEY));
      do_close = open_q && key_wr && (acc_wdata == DAT_W'(RELOCK_KEY));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trk_q  <= TRK_IDLE;
         open_q <= 1'b0;
      end else begin
         if (do_open)       open_q <= 1'b1;
         else if (do_close) open_q <= 1'b0;

         if (open_q || do_open)  trk_q <= TRK_IDLE;
         else if (acc_vld)       trk_q <= trk_next(trk_q, qual_rd);
      end
   end

   assign open_o = open_q;

endmodule

// File: rtl/ide_win_bank.sv
module ide_win_bank #(
   parameter int DAT_W  = 8,
   parameter int ADDR_W = 4,
   parameter int NDRV   = 2,
   localparam int DSW   = $clog2(NDRV)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_rd,
   input  logic              ld_wr,
   input  logic              ld_misc,
   input  logic              commit,
   input  logic [DAT_W-1:0]  wdata,
   input  logic [DSW-1:0]    drv_sel,
   output logic [DSW-1:0]    sel_o,
   output logic [DAT_W-1:0]  stg_rd_o,
   output logic [DAT_W-1:0]  stg_wr_o,
   output logic [ADDR_W-1:0] stg_addr_o,
   output logic [DAT_W-1:0]  act_rd_o,
   output logic [DAT_W-1:0]  act_wr_o,
   output logic [ADDR_W-1:0] act_addr_o
);

   localparam int ADDR_LSB = DAT_W - ADDR_W;

   logic [DSW-1:0]                sel_q;
   logic [NDRV-1:0][DAT_W-1:0]    stg_rd, stg_wr, act_rd, act_wr;
   logic [NDRV-1:0][ADDR_W-1:0]   stg_addr, act_addr;
   logic [DSW-1:0]                wsel;

   assign wsel = wdata[DSW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)       sel_q <= '0;
      else if (ld_misc) sel_q <= wsel;
   end

   for (genvar g = 0; g < NDRV; g++) begin : g_drv
      logic [DAT_W-1:0]  rd_s, wr_s, rd_a, wr_a;
      logic [ADDR_W-1:0] ad_s, ad_a;
      logic              hit_cur, hit_new;

      assign hit_cur = (sel_q == DSW'(g));
      assign hit_new = (wsel == DSW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_s <= '0;
            wr_s <= '0;
            ad_s <= '0;
            rd_a <= '0;
            wr_a <= '0;
            ad_a <= '0;
         end else begin
            if (ld_rd && hit_cur)   rd_s <= wdata;
            if (ld_wr && hit_cur)   wr_s <= wdata;
            if (ld_misc && hit_new) ad_s <= wdata[DAT_W-1:ADDR_LSB];
            if (commit) begin
               rd_a <= rd_s;
               wr_a <= wr_s;
               ad_a <= ad_s;
            end
         end
      end

      assign stg_rd[g]   = rd_s;
      assign stg_wr[g]   = wr_s;
      assign stg_addr[g] = ad_s;
      assign act_rd[g]   = rd_a;
      assign act_wr[g]   = wr_a;
      assign act_addr[g] = ad_a;
   end

   assign sel_o      = sel_q;
   assign stg_rd_o   = stg_rd[sel_q];
   assign stg_wr_o   = stg_wr[sel_q];
   assign stg_addr_o = stg_addr[sel_q];
   assign act_rd_o   = act_rd[drv_sel];
   assign act_wr_o   = act_wr[drv_sel];
   assign act_addr_o = act_addr[drv_sel];

endmodule

// File: rtl/ide_cfg_window.sv
module ide_cfg_window #(
   parameter int DAT_W      = 8,
   parameter int OFS_W      = 3,
   parameter int ADDR_W     = 4,
   parameter int NDRV       = 2,
   parameter int UNLOCK_KEY = 8'h03,
   parameter int RELOCK_KEY = 8'h83,
   parameter int COMMIT_KEY = 8'h85,
   parameter int OFS_RD     = 0,
   parameter int OFS_WR     = 1,
   parameter int OFS_KEY    = 2,
   parameter int OFS_CTL    = 3,
   parameter int OFS_STRAP  = 5,
   parameter int OFS_MISC   = 6,
   localparam int DSW       = $clog2(NDRV)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_vld,
   input  logic              acc_wr,
   input  logic              acc_wide,
   input  logic [OFS_W-1:0]  acc_ofs,
   input  logic [DAT_W-1:0]  acc_wdata,
   output logic [DAT_W-1:0]  acc_rdata,
   output logic              tf_vld,
   output logic              tf_wr,
   output logic              tf_wide,
   output logic [OFS_W-1:0]  tf_ofs,
   output logic [DAT_W-1:0]  tf_wdata,
   input  logic [DAT_W-1:0]  tf_rdata,
   input  logic              strap_pin,
   input  logic [DSW-1:0]    drv_sel,
   output logic              win_open,
   output logic [DAT_W-1:0]  act_rd_tim,
   output logic [DAT_W-1:0]  act_wr_tim,
   output logic [ADDR_W-1:0] act_addr
);

   localparam int PAD_W = DAT_W - ADDR_W - DSW;

   // elaboration-time parameter checks
   if (NDRV < 2 || (1 << DSW) != NDRV) begin : g_bad_ndrv
      $error("NDRV must be a power of two, at least 2");
   end
   if (PAD_W < 0) begin : g_bad_addr
      $error("address field and drive select do not fit in one register");
   end
   if (OFS_W < 3) begin : g_bad_ofs
      $error("offset width too small for the register map");
   end

   logic             open_w;
   logic             cfg_wr;
   logic             ld_rd, ld_wr, ld_misc, ld_ctl, commit;
   logic [DSW-1:0]   sel_w;
   logic [DAT_W-1:0] stg_rd_w, stg_wr_w;
   logic [ADDR_W-1:0] stg_addr_w;
   logic [DAT_W-1:0] ctl_q;
   logic             strap_q;
   logic [DAT_W-1:0] cfg_rdata;

   ide_win_lock #(
      .OFS_W(OFS_W), .DAT_W(DAT_W), .OFS_SEQ(OFS_WR), .OFS_KEY(OFS_KEY),
      .UNLOCK_KEY(UNLOCK_KEY), .RELOCK_KEY(RELOCK_KEY)
   ) u_lock (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
      .acc_wide(acc_wide), .acc_ofs(acc_ofs), .acc_wdata(acc_wdata),
      .open_o(open_w)
   );

   always_comb begin
      cfg_wr  = open_w && acc_vld && acc_wr;
      ld_rd   = cfg_wr && (acc_ofs == OFS_W'(OFS_RD));
      ld_wr   = cfg_wr && (acc_ofs == OFS_W'(OFS_WR));
      ld_misc = cfg_wr && (acc_ofs == OFS_W'(OFS_MISC));
      ld_ctl  = cfg_wr && (acc_ofs == OFS_W'(OFS_CTL));
      commit  = ld_ctl && (acc_wdata == DAT_W'(COMMIT_KEY));
   end

   ide_win_bank #(
      .DAT_W(DAT_W), .ADDR_W(ADDR_W), .NDRV(NDRV)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .ld_rd(ld_rd), .ld_wr(ld_wr),
      .ld_misc(ld_misc), .commit(commit), .wdata(acc_wdata),
      .drv_sel(drv_sel), .sel_o(sel_w), .stg_rd_o(stg_rd_w),
      .stg_wr_o(stg_wr_w), .stg_addr_o(stg_addr_w),
      .act_rd_o(act_rd_tim), .act_wr_o(act_wr_tim), .act_addr_o(act_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ld_ctl) ctl_q <= acc_wdata;
   end

   // strap follows the pin while reset is held, then freezes
   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= strap_pin;
   end

   always_comb begin
      cfg_rdata = '0;
      if (acc_ofs == OFS_W'(OFS_RD))         cfg_rdata = stg_rd_w;
      else if (acc_ofs == OFS_W'(OFS_WR))    cfg_rdata = stg_wr_w;
      else if (acc_ofs == OFS_W'(OFS_CTL))   cfg_rdata = ctl_q;
      else if (acc_ofs == OFS_W'(OFS_STRAP)) cfg_rdata = {{(DAT_W-1){1'b0}}, strap_q};
      else if (acc_ofs == OFS_W'(OFS_MISC))
         cfg_rdata = {stg_addr_w, {PAD_W{1'b0}}, sel_w};
   end

   assign acc_rdata = open_w ? cfg_rdata : tf_rdata;
   assign tf_vld    = acc_vld && !open_w;
   assign tf_wr     = acc_wr;
   assign tf_wide   = acc_wide;
   assign tf_ofs    = acc_ofs;
   assign tf_wdata  = acc_wdata;
   assign win_open  = open_w;

endmodule

// File: rtl/ide_cfg_window_chk.sv
module ide_cfg_window_chk #(
   parameter int DAT_W      = 8,
   parameter int OFS_W      = 3,
   parameter int ADDR_W     = 4,
   parameter int DSW        = 1,
   parameter int UNLOCK_KEY = 8'h03,
   parameter int RELOCK_KEY = 8'h83,
   parameter int COMMIT_KEY = 8'h85,
   parameter int OFS_KEY    = 2,
   parameter int OFS_CTL    = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_vld,
   input logic              acc_wr,
   input logic              acc_wide,
   input logic [OFS_W-1:0]  acc_ofs,
   input logic [DAT_W-1:0]  acc_wdata,
   input logic              tf_vld,
   input logic [DSW-1:0]    drv_sel,
   input logic              win_open,
   input logic [DAT_W-1:0]  act_rd_tim,
   input logic [DAT_W-1:0]  act_wr_tim,
   input logic [ADDR_W-1:0] act_addr
);

   logic key_open, key_close, commit_wr;
   assign key_open  = acc_vld && acc_wr && !acc_wide && acc_ofs == OFS_W'(OFS_KEY)
                      && acc_wdata == DAT_W'(UNLOCK_KEY);
   assign key_close = acc_vld && acc_wr && !acc_wide && acc_ofs == OFS_W'(OFS_KEY)
                      && acc_wdata == DAT_W'(RELOCK_KEY);
   assign commit_wr = win_open && acc_vld && acc_wr && acc_ofs == OFS_W'(OFS_CTL)
                      && acc_wdata == DAT_W'(COMMIT_KEY);

   // R1: the window only opens on the edge of an unlock key write
   p_open_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_open && !key_open) |=> !win_open);

   // R2: locked accesses reach the task file
   p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !win_open |-> (tf_vld == acc_vld));

   // R3: task file hidden while open
   p_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
      win_open |-> !tf_vld);

   // R4: relock key closes the window
   p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (win_open && key_close) |=> !win_open);

   // R8: committed outputs hold unless a commit happens
   p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_wr |=> (!$stable(drv_sel) ||
                      ($stable(act_rd_tim) && $stable(act_wr_tim) && $stable(act_addr))));

endmodule

bind ide_cfg_window ide_cfg_window_chk #(
   .DAT_W(DAT_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .DSW(DSW),
   .UNLOCK_KEY(UNLOCK_KEY), .RELOCK_KEY(RELOCK_KEY), .COMMIT_KEY(COMMIT_KEY),
   .OFS_KEY(OFS_KEY), .OFS_CTL(OFS_CTL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
   .acc_wide(acc_wide), .acc_ofs(acc_ofs), .acc_wdata(acc_wdata),
   .tf_vld(tf_vld), .drv_sel(drv_sel), .win_open(win_open),
   .act_rd_tim(act_rd_tim), .act_wr_tim(act_wr_tim), .act_addr(act_addr)
);

// File: tb/sim_ide_cfg_window.sv
`timescale 1ns/1ps
module sim_ide_cfg_window;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_vld = 1'b0, acc_wr = 1'b0, acc_wide = 1'b0;
   logic [2:0] acc_ofs = '0;
   logic [7:0] acc_wdata = '0;
   logic [7:0] acc_rdata;
   logic       tf_vld, tf_wr, tf_wide;
   logic [2:0] tf_ofs;
   logic [7:0] tf_wdata;
   logic [7:0] tf_rdata = 8'hA5;
   logic       strap_pin = 1'b1;
   logic [0:0] drv_sel = '0;
   logic       win_open;
   logic [7:0] act_rd_tim, act_wr_tim;
   logic [3:0] act_addr;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] rd;
   logic       tfv;

   always #2.5 clk = ~clk;

   ide_cfg_window u0 (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
      .acc_wide(acc_wide), .acc_ofs(acc_ofs), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .tf_vld(tf_vld), .tf_wr(tf_wr), .tf_wide(tf_wide),
      .tf_ofs(tf_ofs), .tf_wdata(tf_wdata), .tf_rdata(tf_rdata),
      .strap_pin(strap_pin), .drv_sel(drv_sel), .win_open(win_open),
      .act_rd_tim(act_rd_tim), .act_wr_tim(act_wr_tim), .act_addr(act_addr)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // one access: drive at falling edge, sample read data and strobe 1 ns later
   task automatic acc(input logic wr, input logic wide, input logic [2:0] ofs,
                      input logic [7:0] wd);
      @(negedge clk);
      acc_vld = 1'b1; acc_wr = wr; acc_wide = wide; acc_ofs = ofs; acc_wdata = wd;
      #1;
      rd  = acc_rdata;
      tfv = tf_vld;
      @(negedge clk);
      acc_vld = 1'b0; acc_wr = 1'b0;
      #1;
   endtask

   task automatic do_unlock();
      acc(1'b0, 1'b1, 3'd1, 8'h00);
      acc(1'b0, 1'b1, 3'd1, 8'h00);
      acc(1'b1, 1'b0, 3'd2, 8'h03);
   endtask

   task automatic show_drive(input logic d);
      @(negedge clk);
      drv_sel = d;
      #1;
   endtask

   task automatic t_reset();
      check("R10 win_open after reset", win_open, 0);
      check("R10 act_rd after reset", act_rd_tim, 0);
      check("R10 act_wr after reset", act_wr_tim, 0);
      check("R10 act_addr after reset", act_addr, 0);
   endtask

   task automatic t_bad_seq();
      tf_rdata = 8'h3C;
      acc(1'b0, 1'b1, 3'd1, 8'h00);
      check("R2 locked read forwards strobe", tfv, 1);
      check("R2 locked read returns task file", rd, 8'h3C);
      acc(1'b1, 1'b0, 3'd2, 8'h03);
      check("R2 one read only", win_open, 0);
      acc(1'b0, 1'b1, 3'd1, 8'h00);
      acc(1'b0, 1'b1, 3'd0, 8'h00);
      acc(1'b1, 1'b0, 3'd2, 8'h03);
      check("R2 read at other offset", win_open, 0);
      acc(1'b0, 1'b1, 3'd1, 8'h00);
      acc(1'b0, 1'b0, 3'd1, 8'h00);
      acc(1'b1, 1'b0, 3'd2, 8'h03);
      check("R2 narrow second read", win_open, 0);
      acc(1'b0, 1'b1, 3'd1, 8'h00);
      acc(1'b1, 1'b0, 3'd7, 8'h00);
      acc(1'b0, 1'b1, 3'd1, 8'h00);
      acc(1'b1, 1'b0, 3'd2, 8'h03);
      check("R2 intervening write", win_open, 0);
      acc(1'b0, 1'b1, 3'd1, 8'h00);
      acc(1'b0, 1'b1, 3'd1, 8'h00);
      acc(1'b1, 1'b0, 3'd2, 8'h04);
      check("R2 wrong key", win_open, 0);
      check("R2 key write forwarded", tfv, 1);
   endtask

   task automatic t_unlock();
      do_unlock();
      check("R1 window opens", win_open, 1);
      tf_rdata = 8'hFF;
      acc(1'b0, 1'b0, 3'd0, 8'h00);
      check("R3 no task-file strobe", tfv, 0);
      check("R3 bank data not task file", rd, 8'h00);
      check("R10 staged read timing zero", rd, 0);
      acc(1'b0, 1'b0, 3'd6, 8'h00);
      check("R10 misc zero", rd, 0);
      acc(1'b0, 1'b0, 3'd3, 8'h00);
      check("R10 control zero", rd, 0);
   endtask

   task automatic t_timing();
      acc(1'b1, 1'b0, 3'd6, 8'h20);
      acc(1'b1, 1'b0, 3'd0, 8'h59);
      acc(1'b1, 1'b0, 3'd1, 8'h46);
      acc(1'b1, 1'b0, 3'd6, 8'h31);
      acc(1'b1, 1'b0, 3'd0, 8'h76);
      acc(1'b1, 1'b0, 3'd1, 8'h54);
      acc(1'b0, 1'b0, 3'd0, 8'h00);
      check("R5 drive1 read timing", rd, 8'h76);
      acc(1'b0, 1'b0, 3'd1, 8'h00);
      check("R5 drive1 write timing", rd, 8'h54);
      acc(1'b0, 1'b0, 3'd6, 8'h00);
      check("R6 misc readback drive1", rd, 8'h31);
      acc(1'b1, 1'b0, 3'd6, 8'h20);
      acc(1'b0, 1'b0, 3'd0, 8'h00);
      check("R5 drive0 read timing", rd, 8'h59);
      acc(1'b0, 1'b0, 3'd1, 8'h00);
      check("R5 drive0 write timing", rd, 8'h46);
      acc(1'b0, 1'b0, 3'd6, 8'h00);
      check("R6 misc readback drive0", rd, 8'h20);
      check("R8 no commit yet", act_rd_tim, 0);
   endtask

   task automatic t_commit();
      acc(1'b1, 1'b0, 3'd3, 8'h84);
      check("R7 wrong value no commit", act_rd_tim, 0);
      acc(1'b0, 1'b0, 3'd3, 8'h00);
      check("R7 control readback", rd, 8'h84);
      acc(1'b1, 1'b0, 3'd3, 8'h85);
      show_drive(1'b0);
      check("R7 drive0 read committed", act_rd_tim, 8'h59);
      check("R7 drive0 write committed", act_wr_tim, 8'h46);
      check("R7 drive0 addr committed", act_addr, 4'h2);
      show_drive(1'b1);
      check("R8 drive1 read", act_rd_tim, 8'h76);
      check("R8 drive1 write", act_wr_tim, 8'h54);
      check("R8 drive1 addr", act_addr, 4'h3);
      show_drive(1'b0);
      acc(1'b1, 1'b0, 3'd0, 8'h11);
      check("R8 staging does not move active", act_rd_tim, 8'h59);
   endtask

   task automatic t_strap();
      acc(1'b0, 1'b0, 3'd5, 8'h00);
      check("R9 strap reads 25 MHz", rd, 8'h01);
      acc(1'b1, 1'b0, 3'd5, 8'hFE);
      acc(1'b0, 1'b0, 3'd5, 8'h00);
      check("R9 strap write ignored", rd, 8'h01);
   endtask

   task automatic t_spare();
      acc(1'b1, 1'b0, 3'd4, 8'hFF);
      acc(1'b1, 1'b0, 3'd7, 8'hFF);
      acc(1'b0, 1'b0, 3'd4, 8'h00);
      check("R11 offset 4 reads zero", rd, 0);
      acc(1'b0, 1'b0, 3'd7, 8'h00);
      check("R11 offset 7 reads zero", rd, 0);
      acc(1'b0, 1'b0, 3'd0, 8'h00);
      check("R11 read timing untouched", rd, 8'h11);
      acc(1'b0, 1'b0, 3'd6, 8'h00);
      check("R11 misc untouched", rd, 8'h20);
      acc(1'b0, 1'b0, 3'd3, 8'h00);
      check("R11 control untouched", rd, 8'h85);
   endtask

   task automatic t_relock();
      acc(1'b1, 1'b0, 3'd2, 8'h84);
      check("R4 other value keeps open", win_open, 1);
      acc(1'b1, 1'b0, 3'd2, 8'h83);
      check("R4 relock closes", win_open, 0);
      tf_rdata = 8'h5A;
      acc(1'b0, 1'b0, 3'd0, 8'h00);
      check("R4 task file back", rd, 8'h5A);
      acc(1'b0, 1'b1, 3'd1, 8'h00);
      acc(1'b0, 1'b1, 3'd1, 8'h00);
      acc(1'b0, 1'b1, 3'd1, 8'h00);
      acc(1'b1, 1'b0, 3'd2, 8'h03);
      check("R1 three reads then key opens", win_open, 1);
      check("R8 active kept across relock", act_rd_tim, 8'h59);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      strap_pin = 1'b0;
      #1;
      t_reset();
      t_bad_seq();
      t_unlock();
      t_timing();
      t_commit();
      t_strap();
      t_spare();
      t_relock();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule